// File: doc/BRIEF.md
# Display-File Character Fetcher with NOP Substitution

This block lets a CPU walk through a display file as if it were code. When the CPU fetches an opcode from the upper half of memory and the fetched byte has bit 6 clear, the block captures the byte as a character code. It then pulls the whole CPU data bus to zero, so the CPU reads a NOP and runs on to the next byte. In the refresh cycle that follows, the block supplies the low nine bits of the refresh address: six from the captured code and three from a line counter. The CPU's own refresh register supplies the upper bits, so the address points at the pattern-table row for that character on the current scan line.

The pattern byte read at that address is loaded into a shift register. The register sends out eight pixels, most significant bit first, at twice the CPU clock rate. When bit 7 of the captured code is set, the pixel stream is inverted. A HALT or any other opcode with bit 6 set passes through untouched. A hires control input stops the block from driving the refresh address, so software can build the whole refresh address itself.

The block runs on one clock at the pixel rate. The input `cpu_rise` marks every clock edge that is also a rising edge of the CPU clock. Every other edge is a falling edge of the CPU clock.

The sequencer has five named states:
- `ST_IDLE` waits for a qualifying fetch.
- `ST_CAPT` holds the captured code through the high phase of T2.
- `ST_NOP` forces the bus to zero until refresh is seen.
- `ST_RFSH_A` covers the first CPU-rise of the refresh window and drives the address.
- `ST_RFSH_B` also drives the address and waits for the next CPU-rise, which loads the pattern.

The transitions are:
- capture: `ST_IDLE` to `ST_CAPT`
- force: `ST_CAPT` to `ST_NOP` on the next falling edge
- refresh-seen: `ST_NOP` to `ST_RFSH_A`
- mid-refresh: `ST_RFSH_A` to `ST_RFSH_B` on a CPU-rise
- load: `ST_RFSH_B` to `ST_IDLE` on a CPU-rise

Top module: `dfile_video_fetch`

## Requirements
- R1: After reset `nop_force`, `vaddr_oe` and `pixel` are 0, and `vaddr` is all zeros (line counter 0, captured code 0).
- R2: A capture happens on a clock edge with `cpu_rise`=1, `m1_n`=0, `a15`=1, `halt_n`=1 and `data_in[6]`=0. On that edge bits 5..0 and bit 7 of `data_in` are stored.
- R3: `nop_force` goes to 1 after the edge that follows the capture edge. It stays 1 through the next CPU-rise edge. It drops on the first edge at which `rfsh_n` is sampled 0.
- R4: From that same edge until the pattern load, `vaddr_oe`=1 and `vaddr` = {code bits 5..0, line count 2..0}.
- R5: The line count increments modulo 8 on each edge that samples `hsync` rising (0 then 1). It is cleared on any edge that samples `vsync`=1, and the clear wins when both happen on one edge. The count is visible on `vaddr[2:0]` at all times.
- R6: The second CPU-rise edge of the refresh window loads `data_in` into the shifter and ends `vaddr_oe`. After that edge `pixel` shows bits 7, 6, ... 0, one per clock.
- R7: If the captured bit 7 was 1, every pixel emitted after that load is inverted.
- R8: With `hires_mode`=1, `vaddr_oe` stays 0 through the refresh window. NOP forcing and the pattern load behave as without it.
- R9: Once eight pixels have left the shifter and no new load has come, zeros follow. `pixel` then stays at 0, or at 1 if the last load was inverted.
- R10: A fetch with `data_in[6]`=1, with `a15`=0 or with `halt_n`=0 leaves `nop_force` and `vaddr_oe` at 0 and loads nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock (twice the CPU clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rise | input | 1 | 1 when the coming edge is a CPU-clock rising edge |
| m1_n | input | 1 | CPU opcode-fetch strobe, active low |
| rfsh_n | input | 1 | CPU refresh strobe, active low |
| halt_n | input | 1 | CPU halt status, active low |
| a15 | input | 1 | CPU address bit 15 |
| data_in | input | 8 | CPU data bus as seen from memory |
| hsync | input | 1 | Horizontal sync, line counter advances on its rise |
| vsync | input | 1 | Vertical sync, clears the line counter |
| hires_mode | input | 1 | 1 = do not drive the refresh address bits |
| nop_force | output | 1 | 1 = pull the CPU data bus to all zeros |
| vaddr | output | 9 | Refresh address low bits {code, line} |
| vaddr_oe | output | 1 | Output enable for `vaddr` |
| pixel | output | 1 | Serial video pixel |

## Verification
Two pairs of functions can land on the same edge.

The first pair is an `hsync` rise inside the refresh window, while the address is being driven. The bench raises `hsync` so its rise is sampled on the mid-refresh CPU-rise. It then expects the old line count on `vaddr[2:0]` before that edge and the new count after it, with `vaddr_oe` still 1.

The second pair is `vsync` and an `hsync` rise sampled on one edge. The clear must win, leaving line count 0.

The bench sweeps all 128 codes with bit 6 clear, with both inversion settings. It checks every pixel of every character against the pattern byte it supplied.

// File: rtl/dvf_pkg.sv
package dvf_pkg;

    // Sequencer states for one display-character fetch.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CAPT   = 3'd1,
        ST_NOP    = 3'd2,
        ST_RFSH_A = 3'd3,
        ST_RFSH_B = 3'd4
    } fetch_st_t;

    localparam int DVF_DATA_W = 8;
    localparam int DVF_ROW_W  = 3;

endpackage

// File: rtl/dvf_rowctr.sv
module dvf_rowctr #(
    parameter int ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic             vsync,
    output logic [ROW_W-1:0] row
);
    logic hs_q;
    logic hs_rise;

    assign hs_rise = hsync & ~hs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            row  <= '0;
        end else begin
            hs_q <= hsync;
            if (vsync) begin
                row <= '0;
            end else if (hs_rise) begin
                row <= row + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dvf_seq.sv
module dvf_seq
    import dvf_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CODE_W  = DATA_W - 2,
    localparam int SEL_BIT = DATA_W - 2,
    localparam int INV_BIT = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rise,
    input  logic              m1_n,
    input  logic              rfsh_n,
    input  logic              halt_n,
    input  logic              a15,
    input  logic [DATA_W-1:0] data_in,
    output logic [CODE_W-1:0] code,
    output logic              inv_flag,
    output logic              nop_force,
    output logic              rfsh_win,
    output logic              load_now
);
    fetch_st_t st, st_nx;
    logic      hit;

    // A display character: upper-half opcode fetch, bit 6 clear, CPU running.
    assign hit = cpu_rise & ~m1_n & a15 & halt_n & ~data_in[SEL_BIT];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (hit)       st_nx = ST_CAPT;
            ST_CAPT:   if (!cpu_rise) st_nx = ST_NOP;
            ST_NOP:    if (!rfsh_n)   st_nx = ST_RFSH_A;
            ST_RFSH_A: if (cpu_rise)  st_nx = ST_RFSH_B;
            ST_RFSH_B: if (cpu_rise)  st_nx = ST_IDLE;
            default:                  st_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        nop_force = 1'b0;
        rfsh_win  = 1'b0;
        load_now  = 1'b0;
        unique case (st)
            ST_IDLE:   ;
            ST_CAPT:   ;
            ST_NOP:    nop_force = 1'b1;
            ST_RFSH_A: rfsh_win  = 1'b1;
            ST_RFSH_B: begin
                rfsh_win = 1'b1;
                load_now = cpu_rise;
            end
            default:   ;
        endcase
    end

    // Character latch: code bits and the inversion bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code     <= '0;
            inv_flag <= 1'b0;
        end else if (st == ST_IDLE && hit) begin
            code     <= data_in[CODE_W-1:0];
            inv_flag <= data_in[INV_BIT];
        end
    end

endmodule

// File: rtl/dvf_shifter.sv
module dvf_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              inv_in,
    output logic              pixel
);
    logic [DATA_W-1:0] sreg;
    logic              inv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg  <= '0;
            inv_q <= 1'b0;
        end else if (load) begin
            sreg  <= din;
            inv_q <= inv_in;
        end else begin
            sreg <= {sreg[DATA_W-2:0], 1'b0};
        end
    end

    assign pixel = sreg[DATA_W-1] ^ inv_q;

endmodule

// File: rtl/dfile_video_fetch.sv
module dfile_video_fetch #(
    parameter int DATA_W = 8,
    parameter int ROW_W  = 3,
    localparam int CODE_W = DATA_W - 2,
    localparam int ADDR_W = CODE_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rise,
    input  logic              m1_n,
    input  logic              rfsh_n,
    input  logic              halt_n,
    input  logic              a15,
    input  logic [DATA_W-1:0] data_in,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              hires_mode,
    output logic              nop_force,
    output logic [ADDR_W-1:0] vaddr,
    output logic              vaddr_oe,
    output logic              pixel
);
    logic [CODE_W-1:0] code;
    logic [ROW_W-1:0]  row;
    logic              inv_flag;
    logic              rfsh_win;
    logic              load_now;

    dvf_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_rise  (cpu_rise),
        .m1_n      (m1_n),
        .rfsh_n    (rfsh_n),
        .halt_n    (halt_n),
        .a15       (a15),
        .data_in   (data_in),
        .code      (code),
        .inv_flag  (inv_flag),
        .nop_force (nop_force),
        .rfsh_win  (rfsh_win),
        .load_now  (load_now)
    );

    dvf_rowctr #(.ROW_W(ROW_W)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .hsync (hsync),
        .vsync (vsync),
        .row   (row)
    );

    dvf_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_now),
        .din    (data_in),
        .inv_in (inv_flag),
        .pixel  (pixel)
    );

    assign vaddr    = {code, row};
    assign vaddr_oe = rfsh_win & ~hires_mode;

endmodule

// File: rtl/dvf_checker.sv
module dvf_checker #(
    parameter int ROW_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_rise,
    input logic             m1_n,
    input logic             rfsh_n,
    input logic             halt_n,
    input logic             a15,
    input logic             sel_bit,
    input logic             hsync,
    input logic             vsync,
    input logic             nop_force,
    input logic             vaddr_oe,
    input logic [ROW_W-1:0] row_bits
);
    // R3: the forced NOP and the address drive never overlap
    a_r3_nop_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nop_force && vaddr_oe));

    // R2 / R10: forcing starts only two edges after a qualifying fetch edge
    a_r2_nop_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nop_force) |-> $past(cpu_rise && !m1_n && a15 && halt_n && !sel_bit, 2));

    // R4: address drive starts on refresh, straight out of the NOP phase
    a_r4_oe_from_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vaddr_oe) |-> ($past(!rfsh_n) && $past(nop_force)));

    // R5: vertical sync clears the line count
    a_r5_vsync_clear: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> (row_bits == '0));

    // R5: a sync rise without vertical sync steps the count by one
    a_r5_hsync_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsync && hsync && !$past(hsync)) |=> (row_bits == $past(row_bits) + 1'b1));

endmodule

bind dfile_video_fetch dvf_checker #(.ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_rise  (cpu_rise),
    .m1_n      (m1_n),
    .rfsh_n    (rfsh_n),
    .halt_n    (halt_n),
    .a15       (a15),
    .sel_bit   (data_in[6]),
    .hsync     (hsync),
    .vsync     (vsync),
    .nop_force (nop_force),
    .vaddr_oe  (vaddr_oe),
    .row_bits  (vaddr[ROW_W-1:0])
);

// File: tb/sim_dfile_video_fetch.sv
module sim_dfile_video_fetch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_rise = 1'b0;
    logic       m1_n = 1'b1;
    logic       rfsh_n = 1'b1;
    logic       halt_n = 1'b1;
    logic       a15 = 1'b1;
    logic [7:0] data_in = 8'h00;
    logic       hsync = 1'b0;
    logic       vsync = 1'b0;
    logic       hires_mode = 1'b0;
    logic       nop_force;
    logic [8:0] vaddr;
    logic       vaddr_oe;
    logic       pixel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench expectations
    int       exp_row = 0;
    bit       hs_prev = 1'b0;
    logic [7:0] cur_pat = 8'h00;
    bit       cur_inv = 1'b0;
    int       idx = 8;
    logic [5:0] cur_code = 6'h00;

    always #4 clk = ~clk;

    dfile_video_fetch u0 (
        .clk(clk), .rst_n(rst_n), .cpu_rise(cpu_rise), .m1_n(m1_n),
        .rfsh_n(rfsh_n), .halt_n(halt_n), .a15(a15), .data_in(data_in),
        .hsync(hsync), .vsync(vsync), .hires_mode(hires_mode),
        .nop_force(nop_force), .vaddr(vaddr), .vaddr_oe(vaddr_oe), .pixel(pixel)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock period: drive at a falling clk edge, judge at the next one.
    task automatic step(input bit cr, input bit m1, input bit rf, input bit hs, input bit vs,
                        input logic [7:0] d, input bit ld, input logic [7:0] lp, input bit li,
                        input bit e_nop, input bit e_oe, input bit chk_addr);
        cpu_rise = cr; m1_n = m1; rfsh_n = rf; hsync = hs; vsync = vs; data_in = d;
        @(negedge clk);
        // R5: line count model
        if (vs) exp_row = 0;
        else if (hs && !hs_prev) exp_row = (exp_row + 1) % 8;
        hs_prev = hs;
        if (ld) begin
            idx = 0; cur_pat = lp; cur_inv = li;
        end
        chk("R5 line count", {13'd0, vaddr[2:0]}, exp_row[15:0]);
        chk("R3 nop_force", {15'd0, nop_force}, {15'd0, e_nop});
        chk("R4/R8 vaddr_oe", {15'd0, vaddr_oe}, {15'd0, e_oe});
        if (chk_addr)
            chk("R4 refresh address", {7'd0, vaddr}, {7'd0, cur_code, exp_row[2:0]});
        // R6 R7 R9: serial pixel
        chk("R6/R7/R9 pixel", {15'd0, pixel},
            {15'd0, ((idx < 8) ? cur_pat[7 - idx] : 1'b0) ^ cur_inv});
        if (idx < 8) idx++;
    endtask

    // One opcode-fetch cycle, 8 pixel clocks, starting just after a CPU rise.
    task automatic fetch(input logic [7:0] op, input logic [7:0] pat, input bit hs6);
        bit v;
        bit oe;
        v  = a15 && halt_n && !op[6];
        oe = v && !hires_mode;
        if (v) cur_code = op[5:0];
        step(0, 0, 1, 0, 0, op,  0, 0, 0, 0, 0, 0);     // T1 low
        step(1, 0, 1, 0, 0, op,  0, 0, 0, 0, 0, 0);     // T2 rise: R2 capture
        step(0, 0, 1, 0, 0, op,  0, 0, 0, v, 0, 0);     // T2 fall: R3 force on
        step(1, 0, 1, 0, 0, op,  0, 0, 0, v, 0, 0);     // T3 rise: R3 still forced
        step(0, 1, 0, 0, 0, pat, 0, 0, 0, 0, oe, oe);   // T3 fall: R4 drive
        step(1, 1, 0, hs6, 0, pat, 0, 0, 0, 0, oe, oe); // T4 rise
        step(0, 1, 0, 0, 0, pat, 0, 0, 0, 0, oe, oe);   // T4 fall
        step(1, 1, 0, 0, 0, pat, v, pat, op[7], 0, 0, 0); // next T1 rise: R6 load
    endtask

    task automatic idle_pair(input bit hs, input bit vs);
        step(0, 1, 1, hs, vs, 8'hFF, 0, 0, 0, 0, 0, 0);
        step(1, 1, 1, 0, 0, 8'hFF, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 nop_force", {15'd0, nop_force}, 16'd0);
        chk("R1 vaddr_oe", {15'd0, vaddr_oe}, 16'd0);
        chk("R1 pixel", {15'd0, pixel}, 16'd0);
        chk("R1 vaddr", {7'd0, vaddr}, 16'd0);
        rst_n = 1'b1;
        idle_pair(0, 0);

        // R2 R4 R6 R7: sweep every display code, both inversion settings
        for (int c = 0; c < 128; c++) begin
            logic [7:0] op;
            logic [7:0] pat;
            op  = {c[6], 1'b0, c[5:0]};
            pat = 8'(c * 37 + 11);
            fetch(op, pat, (c % 16) == 5);   // coincidence: sync rise mid-refresh
            if ((c % 8) == 7) idle_pair(1, 0);
        end

        // R9: stream runs out to zeros after an inverted load -> solid
        fetch(8'h81, 8'hA5, 0);
        for (int k = 0; k < 6; k++) idle_pair(0, 0);
        fetch(8'h02, 8'h3C, 0);
        for (int k = 0; k < 6; k++) idle_pair(0, 0);

        // R10: bit 6 set (HALT), low half, halted CPU are not replaced
        fetch(8'h76, 8'hFF, 0);
        a15 = 1'b0;
        fetch(8'h05, 8'hFF, 0);
        a15 = 1'b1;
        halt_n = 1'b0;
        fetch(8'h00, 8'hFF, 0);
        halt_n = 1'b1;
        for (int k = 0; k < 5; k++) idle_pair(0, 0);

        // R8: hires mode, no address drive, forcing and loading unchanged
        hires_mode = 1'b1;
        fetch(8'h11, 8'hC3, 0);
        fetch(8'h93, 8'h0F, 0);
        hires_mode = 1'b0;
        fetch(8'h2A, 8'h81, 0);

        // R5: wrap past 7, then vsync alone, then vsync together with a sync rise
        for (int k = 0; k < 9; k++) idle_pair(1, 0);
        idle_pair(0, 1);
        idle_pair(1, 0);
        idle_pair(1, 0);
        idle_pair(1, 1);
        fetch(8'h3F, 8'h55, 0);
        idle_pair(0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule